// File: doc/BRIEF.md
# Flash Control Key-Unlock Register File

This block is the software-facing register file of a flash memory controller. It holds the program/erase control word and protects it with three nested locks. The outer lock guards the control word itself. The two inner locks guard program-memory operations and option-byte operations. Each lock opens only after an exact pair of 32-bit magic words is written, in order, to that lock's own key register. The inner locks accept keys only while the outer lock is open. Software may set any lock again at any time. Setting the outer lock also closes both inner locks.

A key path that sees a wrong value, or the right values in the wrong order, jams. It then ignores all further keys until the next reset. The lock states and the control word are driven out to the erase and program engines. A status word and an option readback word come in from outside and can be read through the bus. The bus is a plain 32-bit port with a byte address, a write strobe, write data and read data. Writes take effect at the clock edge. Reads are combinational from the current register state.

Top module: `flkey_regfile`

## Requirements
- R1: After reset the control word reads 0x00000007: control lock (bit 0), program lock (bit 1) and option lock (bit 2) are all 1, and every other field is 0.
- R2: Byte offsets are 0x00 access control (5 bits read/write), 0x04 control word, 0x08 power-down key, 0x0C control key, 0x10 program key, 0x14 option key, 0x18 status input, 0x1C option readback input, 0x20 write-protect (32 bits read/write). The four key offsets read 0. Offsets above 0x20, and any address with nonzero bits [1:0], read 0 and ignore writes.
- R3: Writing 0x89ABCDEF and then 0x02030405 to offset 0x0C clears the control lock. Writes to other offsets between the two keys do not break the sequence.
- R4: While the control lock is clear, writing 0x8C9DAEBF and then 0x13141516 to offset 0x10 clears the program lock. While the control lock is set, writes to 0x10 are ignored and do not advance or jam that path.
- R5: While the control lock is clear, writing 0xFBEAD9C8 and then 0x24252627 to offset 0x14 clears the option lock.
- R6: A wrong value, or a second key written first, jams that key path. Its lock then stays set even for a correct sequence until reset. Reset clears the jam.
- R7: Writing 1 to a lock bit of the control word sets that lock. Writing 0 leaves it unchanged. Setting the control lock (bit 0) also sets the program and option locks.
- R8: The field bits 3, 4, 8, 9, 10, 16, 17 and 18 of the control word take the written value only while the control lock is clear. All other bits above bit 2 always read 0.
- R9: A key write to the control key register while the control lock is already clear is ignored and does not jam that path.
- R10: The lock outputs and the control word output always equal the control word read at offset 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (6) | Byte address of the access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| stat_i | input | 32 | Status word from the flash engine |
| optrd_i | input | 32 | Option readback word from the option loader |
| ctl_locked_o | output | 1 | Control lock state |
| prg_locked_o | output | 1 | Program lock state |
| opt_locked_o | output | 1 | Option lock state |
| op_ctrl_o | output | 32 | Full control word |
| acc_ctrl_o | output | ACC_W (5) | Access control register |
| wprot_o | output | 32 | Write-protect register |

## Verification
The assertions assume a single bus, so a write reaches at most one register per cycle. A key-triggered opening and a software relock therefore never coincide. They also assume reset is applied before the first access. The stimulus follows both rules. It drives one write or one read per cycle, always on the falling edge, and begins with a reset. Wrong keys, wrong order and gated writes are chosen so that each jam or ignore is later shown at the ports by a correct sequence that fails, or one that still succeeds.

// File: rtl/flkey_pkg.sv
package flkey_pkg;

  localparam int unsigned RW        = 32;
  localparam int unsigned NUM_PATHS = 3;

  // lock bit positions inside the control word (decoded by the flash engines)
  localparam int unsigned LK_CTL = 0;
  localparam int unsigned LK_PRG = 1;
  localparam int unsigned LK_OPT = 2;
  localparam int unsigned LK_N   = 3;

  // field bit positions of the control word
  localparam int unsigned BIT_PGM_SEL    = 3;
  localparam int unsigned BIT_WORD_SEL   = 4;
  localparam int unsigned BIT_FIXTIME    = 8;
  localparam int unsigned BIT_ERASE_SEL  = 9;
  localparam int unsigned BIT_HALFPG     = 10;
  localparam int unsigned BIT_DONE_IE    = 16;
  localparam int unsigned BIT_ERR_IE     = 17;
  localparam int unsigned BIT_OPT_RELOAD = 18;

  typedef logic [RW-1:0] word_t;

  typedef enum logic [3:0] {
    SEL_ACC, SEL_OPC, SEL_PWK, SEL_CTK, SEL_PRK,
    SEL_OPK, SEL_STA, SEL_OBV, SEL_WPR, SEL_NONE
  } sel_e;

  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_JAM} kst_e;

  function automatic word_t bit_at(input int unsigned pos);
    return word_t'(1) << pos;
  endfunction

  function automatic word_t field_mask();
    return bit_at(BIT_PGM_SEL) | bit_at(BIT_WORD_SEL) | bit_at(BIT_FIXTIME) |
           bit_at(BIT_ERASE_SEL) | bit_at(BIT_HALFPG) | bit_at(BIT_DONE_IE) |
           bit_at(BIT_ERR_IE) | bit_at(BIT_OPT_RELOAD);
  endfunction

  // byte address to register select; misaligned addresses select nothing
  function automatic sel_e decode_sel(input logic [15:0] a);
    sel_e s;
    if (a[1:0] != 2'b00) return SEL_NONE;
    case (a[15:2])
      14'd0:   s = SEL_ACC;
      14'd1:   s = SEL_OPC;
      14'd2:   s = SEL_PWK;
      14'd3:   s = SEL_CTK;
      14'd4:   s = SEL_PRK;
      14'd5:   s = SEL_OPK;
      14'd6:   s = SEL_STA;
      14'd7:   s = SEL_OBV;
      14'd8:   s = SEL_WPR;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  // path 0 = control, 1 = program, 2 = option
  function automatic word_t key_first(input int unsigned p);
    case (p)
      0:       return 32'h89AB_CDEF;
      1:       return 32'h8C9D_AEBF;
      default: return 32'hFBEA_D9C8;
    endcase
  endfunction

  function automatic word_t key_second(input int unsigned p);
    case (p)
      0:       return 32'h0203_0405;
      1:       return 32'h1314_1516;
      default: return 32'h2425_2627;
    endcase
  endfunction

  function automatic sel_e key_sel(input int unsigned p);
    case (p)
      0:       return SEL_CTK;
      1:       return SEL_PRK;
      default: return SEL_OPK;
    endcase
  endfunction

endpackage

// File: rtl/flkey_seq.sv
module flkey_seq
  import flkey_pkg::*;
#(
  parameter word_t K1 = '0,
  parameter word_t K2 = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  word_t wdata,
  input  logic  enable,
  output logic  open_o
);

  kst_e st_q, st_d;
  logic take;

  assign take = wr_hit && enable;

  always_comb begin
    st_d   = st_q;
    open_o = 1'b0;
    if (take) begin
      case (st_q)
        KS_IDLE: st_d = (wdata == K1) ? KS_HALF : KS_JAM;
        KS_HALF: begin
          if (wdata == K2) begin
            st_d   = KS_IDLE;
            open_o = 1'b1;
          end else begin
            st_d = KS_JAM;
          end
        end
        default: st_d = KS_JAM;
      endcase
    end else if (!enable && st_q == KS_HALF) begin
      // a gate that closes mid-sequence abandons the half-entered pair
      st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  // R6: a jammed path never recovers without reset
  a_r6_jam_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == KS_JAM |=> st_q == KS_JAM);

  // R6: an opening never comes out of a jammed path
  a_r6_no_open_jammed: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == KS_JAM |-> !open_o);

endmodule

// File: rtl/flkey_ctl_reg.sv
module flkey_ctl_reg
  import flkey_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  word_t           wdata,
  input  logic [LK_N-1:0] open_vec,
  output logic [LK_N-1:0] lock_q,
  output word_t           fld_q
);

  localparam word_t FMASK = field_mask();

  logic [LK_N-1:0] set_req;
  logic [LK_N-1:0] lock_d;
  word_t           fld_d;
  logic            fld_wr;

  // a relock of the outer lock closes every inner lock as well
  always_comb begin
    for (int i = 0; i < int'(LK_N); i++) begin
      set_req[i] = wr && (wdata[i] || wdata[LK_CTL]);
    end
  end

  always_comb begin
    for (int i = 0; i < int'(LK_N); i++) begin
      if (set_req[i])       lock_d[i] = 1'b1;
      else if (open_vec[i]) lock_d[i] = 1'b0;
      else                  lock_d[i] = lock_q[i];
    end
  end

  assign fld_wr = wr && !lock_q[LK_CTL];
  assign fld_d  = fld_wr ? (wdata & FMASK) : fld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '1;
      fld_q  <= '0;
    end else begin
      lock_q <= lock_d;
      fld_q  <= fld_d;
    end
  end

  // R3: the outer lock only opens after its key path reported success
  a_r3_ctl_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q[LK_CTL]) |-> $past(open_vec[LK_CTL]));

  // R4: the program lock only opens while the outer lock was open
  a_r4_prg_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q[LK_PRG]) |-> !$past(lock_q[LK_CTL]));

  // R5: the option lock only opens while the outer lock was open
  a_r5_opt_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q[LK_OPT]) |-> !$past(lock_q[LK_CTL]));

  // R7: closing the outer lock leaves both inner locks closed
  a_r7_relock_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q[LK_CTL]) |-> lock_q[LK_PRG] && lock_q[LK_OPT]);

  // R8: fields hold while the outer lock is set
  a_r8_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[LK_CTL] |=> $stable(fld_q));

endmodule

// File: rtl/flkey_rdmux.sv
module flkey_rdmux
  import flkey_pkg::*;
#(
  parameter int unsigned ACC_W = 5
) (
  input  sel_e             sel,
  input  word_t            ctl_word,
  input  logic [ACC_W-1:0] acc_q,
  input  word_t            wprot_q,
  input  word_t            stat_i,
  input  word_t            optrd_i,
  output word_t            rdata
);

  always_comb begin
    case (sel)
      SEL_ACC: rdata = word_t'(acc_q);
      SEL_OPC: rdata = ctl_word;
      SEL_STA: rdata = stat_i;
      SEL_OBV: rdata = optrd_i;
      SEL_WPR: rdata = wprot_q;
      default: rdata = '0; // key registers and unmapped space
    endcase
  end

endmodule

// File: rtl/flkey_regfile.sv
module flkey_regfile
  import flkey_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned ACC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       stat_i,
  input  logic [31:0]       optrd_i,
  output logic              ctl_locked_o,
  output logic              prg_locked_o,
  output logic              opt_locked_o,
  output logic [31:0]       op_ctrl_o,
  output logic [ACC_W-1:0]  acc_ctrl_o,
  output logic [31:0]       wprot_o
);

  sel_e             sel;
  logic [LK_N-1:0]  lock_q;
  logic [LK_N-1:0]  open_vec;
  logic [LK_N-1:0]  path_en;
  logic [LK_N-1:0]  key_wr;
  word_t            fld_q;
  word_t            ctl_word;
  logic [ACC_W-1:0] acc_q;
  word_t            wprot_q;

  assign sel = decode_sel(16'(reg_addr));

  // inner paths listen only while the outer lock is open and their own is shut
  assign path_en[LK_CTL] = lock_q[LK_CTL];
  assign path_en[LK_PRG] = !lock_q[LK_CTL] && lock_q[LK_PRG];
  assign path_en[LK_OPT] = !lock_q[LK_CTL] && lock_q[LK_OPT];

  for (genvar p = 0; p < int'(NUM_PATHS); p++) begin : g_path
    assign key_wr[p] = reg_we && (sel == key_sel(p));
    flkey_seq #(
      .K1(key_first(p)),
      .K2(key_second(p))
    ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(key_wr[p]),
      .wdata (reg_wdata),
      .enable(path_en[p]),
      .open_o(open_vec[p])
    );
  end

  flkey_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_we && sel == SEL_OPC),
    .wdata   (reg_wdata),
    .open_vec(open_vec),
    .lock_q  (lock_q),
    .fld_q   (fld_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      wprot_q <= '0;
    end else if (reg_we) begin
      if (sel == SEL_ACC) acc_q   <= reg_wdata[ACC_W-1:0];
      if (sel == SEL_WPR) wprot_q <= reg_wdata;
    end
  end

  assign ctl_word = fld_q | word_t'(lock_q);

  flkey_rdmux #(.ACC_W(ACC_W)) u_rd (
    .sel     (sel),
    .ctl_word(ctl_word),
    .acc_q   (acc_q),
    .wprot_q (wprot_q),
    .stat_i  (stat_i),
    .optrd_i (optrd_i),
    .rdata   (reg_rdata)
  );

  assign ctl_locked_o = lock_q[LK_CTL];
  assign prg_locked_o = lock_q[LK_PRG];
  assign opt_locked_o = lock_q[LK_OPT];
  assign op_ctrl_o    = ctl_word;
  assign acc_ctrl_o   = acc_q;
  assign wprot_o      = wprot_q;

  // R2: a write to unmapped or misaligned space changes no register
  a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && sel == SEL_NONE |=> $stable(op_ctrl_o) && $stable(wprot_o) && $stable(acc_ctrl_o));

  // R9: a control key write while the outer lock is open leaves the locks alone
  a_r9_ctl_key_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr[LK_CTL] && !lock_q[LK_CTL] |=> $stable(lock_q));

endmodule

// File: tb/tb_flkey_regfile.sv
module tb_flkey_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] stat_i = 32'hA5A5_0001;
  logic [31:0] optrd_i = 32'h00FF_55AA;
  logic        ctl_locked_o, prg_locked_o, opt_locked_o;
  logic [31:0] op_ctrl_o;
  logic [4:0]  acc_ctrl_o;
  logic [31:0] wprot_o;

  always #4 clk = ~clk;

  flkey_regfile dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_i(stat_i),
    .optrd_i(optrd_i), .ctl_locked_o(ctl_locked_o), .prg_locked_o(prg_locked_o),
    .opt_locked_o(opt_locked_o), .op_ctrl_o(op_ctrl_o), .acc_ctrl_o(acc_ctrl_o),
    .wprot_o(wprot_o)
  );

  // bench-side constants restated from the requirements
  localparam logic [31:0] CK1 = 32'h89AB_CDEF, CK2 = 32'h0203_0405;
  localparam logic [31:0] PK1 = 32'h8C9D_AEBF, PK2 = 32'h1314_1516;
  localparam logic [31:0] OK1 = 32'hFBEA_D9C8, OK2 = 32'h2425_2627;
  localparam logic [31:0] FLD = 32'h0007_0718;

  localparam int K_BUS = 0, K_LOCKS = 1, K_OPC = 2, K_ACC = 3, K_WPR = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] actual(input int kind);
    case (kind)
      K_BUS:   return reg_rdata;
      K_LOCKS: return {29'b0, opt_locked_o, prg_locked_o, ctl_locked_o};
      K_OPC:   return op_ctrl_o;
      K_ACC:   return {27'b0, acc_ctrl_o};
      default: return wprot_o;
    endcase
  endfunction

  // monitor: compares everything queued for this cycle once state has settled
  always begin
    @(posedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = actual(it.kind);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_we = 1'b1;
    reg_wdata = d;
  endtask

  task automatic chk(input int kind, input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_we = 1'b0;
    reg_addr = a;
    it.kind = kind;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    reg_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state, R10 pins mirror it
    chk(K_BUS, 6'h04, 32'h7, "R1 reset control word");
    chk(K_LOCKS, 6'h00, 32'h7, "R10 reset lock pins");
    chk(K_OPC, 6'h00, 32'h7, "R10 reset control pins");

    // R8 fields frozen while locked
    wr(6'h04, 32'hFFFF_FFF8);
    chk(K_BUS, 6'h04, 32'h7, "R8 fields ignored while locked");

    // R4 program keys ignored while control locked (also a wrong one: no jam)
    wr(6'h10, 32'h0);
    wr(6'h10, PK1);
    wr(6'h10, PK2);
    chk(K_BUS, 6'h04, 32'h7, "R4 program keys gated");

    // R3 control unlock with an unrelated write in between
    wr(6'h0C, CK1);
    wr(6'h20, 32'h0000_00F0);
    wr(6'h0C, CK2);
    chk(K_BUS, 6'h04, 32'h6, "R3 control lock cleared");
    chk(K_LOCKS, 6'h00, 32'h6, "R10 lock pins after control unlock");

    // R2 address map
    chk(K_BUS, 6'h20, 32'hF0, "R2 write-protect readback");
    chk(K_WPR, 6'h00, 32'hF0, "R2 write-protect pins");
    wr(6'h00, 32'hFFFF_FFFF);
    chk(K_BUS, 6'h00, 32'h1F, "R2 access control width");
    chk(K_ACC, 6'h00, 32'h1F, "R2 access control pins");
    chk(K_BUS, 6'h18, 32'hA5A5_0001, "R2 status read");
    chk(K_BUS, 6'h1C, 32'h00FF_55AA, "R2 option readback");
    chk(K_BUS, 6'h08, 32'h0, "R2 power-down key reads 0");
    chk(K_BUS, 6'h0C, 32'h0, "R2 control key reads 0");
    chk(K_BUS, 6'h10, 32'h0, "R2 program key reads 0");
    chk(K_BUS, 6'h14, 32'h0, "R2 option key reads 0");
    chk(K_BUS, 6'h24, 32'h0, "R2 unmapped reads 0");
    chk(K_BUS, 6'h05, 32'h0, "R2 misaligned read 0");
    wr(6'h21, 32'h1);
    chk(K_WPR, 6'h00, 32'hF0, "R2 misaligned write ignored");

    // R9 stray control key while open: ignored, no jam (shown later)
    wr(6'h0C, 32'h1234_5678);
    chk(K_BUS, 6'h04, 32'h6, "R9 stray control key ignored");

    // R4 program unlock
    wr(6'h10, PK1);
    wr(6'h10, PK2);
    chk(K_BUS, 6'h04, 32'h4, "R4 program lock cleared");

    // R8 fields writable while unlocked, only the field bits stick
    wr(6'h04, 32'hFFFF_FFF8);
    chk(K_BUS, 6'h04, FLD | 32'h4, "R8 field bits written");
    chk(K_OPC, 6'h00, FLD | 32'h4, "R10 control pins follow fields");

    // R7 relock program alone; zeros do not open locks
    wr(6'h04, FLD | 32'h2);
    chk(K_BUS, 6'h04, FLD | 32'h6, "R7 program relock");
    wr(6'h04, 32'h0);
    chk(K_BUS, 6'h04, 32'h6, "R7 zero leaves locks set");

    // R5 option unlock
    wr(6'h14, OK1);
    wr(6'h14, OK2);
    chk(K_BUS, 6'h04, 32'h2, "R5 option lock cleared");

    // R7 control relock closes everything
    wr(6'h04, 32'h1);
    chk(K_BUS, 6'h04, 32'h7, "R7 control relock cascades");
    chk(K_LOCKS, 6'h00, 32'h7, "R7 lock pins after cascade");

    // R9 control path not jammed by earlier stray write
    wr(6'h0C, CK1);
    wr(6'h0C, CK2);
    chk(K_BUS, 6'h04, 32'h6, "R9 control reopens after stray key");

    // R6 wrong order jams the program path
    wr(6'h10, PK2);
    wr(6'h10, PK1);
    wr(6'h10, PK2);
    chk(K_BUS, 6'h04, 32'h6, "R6 program path jammed");

    // R6 wrong value jams the control path
    wr(6'h04, 32'h1);
    wr(6'h0C, 32'hDEAD_BEEF);
    wr(6'h0C, CK1);
    wr(6'h0C, CK2);
    chk(K_BUS, 6'h04, 32'h7, "R6 control path jammed");

    // R6 reset clears jams
    do_reset();
    chk(K_BUS, 6'h04, 32'h7, "R1 control word after second reset");
    wr(6'h0C, CK1);
    wr(6'h0C, CK2);
    chk(K_BUS, 6'h04, 32'h6, "R6 control path free after reset");
    wr(6'h10, PK1);
    wr(6'h10, PK2);
    chk(K_BUS, 6'h04, 32'h4, "R6 program path free after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule